// File: doc/BRIEF.md
# Always-On GPIO Controller with Interrupt Window

This block is a memory-mapped general-purpose I/O controller for a power domain that stays on while the rest of the chip sleeps. It serves up to 22 pins. Each pin can be an input or a driven output. Every input is brought into the clock domain through a two-flop synchroniser. A simple 32-bit register bus gives software five registers: output enable, output value, input state, function select and interrupt polarity. Software changes single pins by read-modify-write.

A fixed, contiguous window of pins (pins 8 to 13 by default) can be switched into interrupt mode, one pin at a time, through a two-bit field per pin in the function-select register. Each interrupt has its own polarity bit. The block always presents active-high interrupt lines to the parent interrupt controller, so a pin programmed as active-low is inverted before it leaves the block. The interrupt outputs are registered, which keeps them free of glitches.

Top module: `gpio_aon_ctrl`

## Requirements
- R1: After reset, pin_oe, pin_out and irq_out are all zero. The output-enable, output-value, select and polarity registers read as zero.
- R2: Registers sit at these byte offsets: polarity 0x290, function select 0x294, output enable 0x29C, output value 0x2A0, input state 0x2A4. A write on a clock edge with bus_we high updates only the register that bus_addr names.
- R3: Output-enable bit n drives pin_oe[n], where 1 means the pin is driven. Output-value bit n drives pin_out[n]. Both take a written value from the clock edge that performs the write.
- R4: Input-state bit n shows pin_in[n] through two flops, so a change becomes readable after two rising edges and not after one. Writes to the input-state offset are ignored.
- R5: The function-select register holds 32 bits, which read back as written. Pin n owns bits [2n+1:2n], and bit 2n set to 1 places the pin in interrupt mode. Bit 2n+1 does not enable an interrupt.
- R6: Pin 8+k feeds interrupt index k, irq_out[k], for k = 0 to 5.
- R7: Polarity bit k set to 1 raises irq_out[k] while the synchronised pin is high. Polarity bit k at 0 raises irq_out[k] while the synchronised pin is low. irq_out is registered, so it follows a pin change after three rising edges.
- R8: irq_out[k] is low whenever select bit 2(8+k) is clear. Select bits of pins outside the window never raise any interrupt.
- R9: Reads of unused offsets, including unaligned ones, and of unused upper bits return zero. Writes to unused offsets change no register.
- R10: A change to the select or polarity register reaches irq_out one rising edge after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational from register state) |
| pin_in | input | 22 | Raw pad input levels |
| pin_out | output | 22 | Value driven on each pin |
| pin_oe | output | 22 | Per-pin drive enable (1 = driven, 0 = tri-state input) |
| irq_out | output | 6 | Active-high interrupt lines to the parent controller |

## Verification
A pin edge that has just passed the synchroniser and a software write to the polarity register can land on the same rising edge. The interrupt register then has to combine the new pin level with the new polarity, and neither value may be one cycle stale. The bench provokes this by toggling a window pin and starting a polarity write one cycle later, so that the write edge matches the second synchroniser flop's update. It then judges irq_out on the next cycle against the level computed from both new values, after first showing that the interrupt was already active beforehand.

// File: rtl/gpio_aon_pkg.sv
package gpio_aon_pkg;

    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_POL = 12'h290;
    localparam logic [BUS_AW-1:0] OFS_SEL = 12'h294;
    localparam logic [BUS_AW-1:0] OFS_OE  = 12'h29C;
    localparam logic [BUS_AW-1:0] OFS_OUT = 12'h2A0;
    localparam logic [BUS_AW-1:0] OFS_IN  = 12'h2A4;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_POL,
        REG_SEL,
        REG_OE,
        REG_OUT,
        REG_IN
    } reg_id_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic reg_id_e decode_reg(input logic [BUS_AW-1:0] a);
        case (a)
            OFS_POL: return REG_POL;
            OFS_SEL: return REG_SEL;
            OFS_OE:  return REG_OE;
            OFS_OUT: return REG_OUT;
            OFS_IN:  return REG_IN;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_aon_sync.sv
module gpio_aon_sync #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_aon_regs.sv
module gpio_aon_regs
    import gpio_aon_pkg::*;
#(
    parameter int NPIN = 22,
    parameter int NIRQ = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NPIN-1:0]   in_sync,
    output logic [BUS_DW-1:0] rdata,
    output logic [NPIN-1:0]   oe_q,
    output logic [NPIN-1:0]   out_q,
    output logic [BUS_DW-1:0] sel_q,
    output logic [NIRQ-1:0]   pol_q
);
    reg_id_e hit;

    assign hit = decode_reg(req.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= '0;
            out_q <= '0;
            sel_q <= '0;
            pol_q <= '0;
        end else if (req.we) begin
            case (hit)
                REG_OE:  oe_q  <= req.wdata[NPIN-1:0];
                REG_OUT: out_q <= req.wdata[NPIN-1:0];
                REG_SEL: sel_q <= req.wdata;
                REG_POL: pol_q <= req.wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (hit)
            REG_OE:  rdata[NPIN-1:0] = oe_q;
            REG_OUT: rdata[NPIN-1:0] = out_q;
            REG_IN:  rdata[NPIN-1:0] = in_sync;
            REG_SEL: rdata           = sel_q;
            REG_POL: rdata[NIRQ-1:0] = pol_q;
            default: rdata           = '0;
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (oe_q == '0 && out_q == '0 && sel_q == '0 && pol_q == '0)); // R1

    AST_OE_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.addr == OFS_OE) |=> (oe_q == $past(req.wdata[NPIN-1:0]))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!req.we) |=> ($stable(oe_q) && $stable(out_q) && $stable(sel_q) && $stable(pol_q))); // R9

endmodule

// File: rtl/gpio_aon_irq.sv
module gpio_aon_irq #(
    parameter int NIRQ = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] win_in,
    input  logic [NIRQ-1:0] win_sel,
    input  logic [NIRQ-1:0] pol,
    output logic [NIRQ-1:0] irq
);
    logic [NIRQ-1:0] irq_q;

    for (genvar k = 0; k < NIRQ; k++) begin : g_line
        logic active;
        assign active = win_sel[k] & ~(win_in[k] ^ pol[k]);

        always_ff @(posedge clk) begin
            if (rst) irq_q[k] <= 1'b0;
            else     irq_q[k] <= active;
        end

        AST_IRQ_OFF_IN_GPIO_MODE: assert property (@(posedge clk) disable iff (rst)
            (!win_sel[k]) |=> (!irq[k])); // R8

        AST_IRQ_FOLLOWS_POLARITY: assert property (@(posedge clk) disable iff (rst)
            (win_sel[k] && (win_in[k] == pol[k])) |=> irq[k]); // R7

        AST_IRQ_QUIET_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (rst)
            (win_in[k] != pol[k]) |=> (!irq[k])); // R7
    end

    assign irq = irq_q;

endmodule

// File: rtl/gpio_aon_ctrl.sv
module gpio_aon_ctrl
    import gpio_aon_pkg::*;
#(
    parameter int NPIN     = 22,
    parameter int NIRQ     = 6,
    parameter int IRQ_BASE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NIRQ-1:0]   irq_out
);
    localparam int SEL_PINS = BUS_DW / 2;
    localparam int WIN_TOP  = IRQ_BASE + NIRQ;

    initial begin
        assert (WIN_TOP <= SEL_PINS && WIN_TOP <= NPIN && NPIN <= BUS_DW)
            else $error("interrupt window does not fit the select register");
    end

    bus_req_t          req;
    logic [NPIN-1:0]   in_sync;
    logic [NPIN-1:0]   oe_q;
    logic [NPIN-1:0]   out_q;
    logic [BUS_DW-1:0] sel_q;
    logic [NIRQ-1:0]   pol_q;
    logic [NIRQ-1:0]   win_sel;

    assign req = '{we: bus_we, addr: bus_addr, wdata: bus_wdata};

    gpio_aon_sync #(.WIDTH(NPIN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pin_in),
        .sync_out (in_sync)
    );

    gpio_aon_regs #(.NPIN(NPIN), .NIRQ(NIRQ)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .in_sync (in_sync),
        .rdata   (bus_rdata),
        .oe_q    (oe_q),
        .out_q   (out_q),
        .sel_q   (sel_q),
        .pol_q   (pol_q)
    );

    for (genvar k = 0; k < NIRQ; k++) begin : g_win
        assign win_sel[k] = sel_q[2*(IRQ_BASE+k)];
    end

    gpio_aon_irq #(.NIRQ(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .win_in  (in_sync[IRQ_BASE +: NIRQ]),
        .win_sel (win_sel),
        .pol     (pol_q),
        .irq     (irq_out)
    );

    assign pin_oe  = oe_q;
    assign pin_out = out_q;

    AST_OUT_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_OUT) |=> (pin_out == $past(bus_wdata[NPIN-1:0]))); // R3

    AST_SEL_CHANGE_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_SEL && bus_wdata[2*IRQ_BASE] == 1'b0) |=> ##1 (!irq_out[0])); // R10

endmodule

// File: tb/gpio_aon_ctrl_tb.sv
module gpio_aon_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [21:0] pin_in;
    logic [21:0] pin_out;
    logic [21:0] pin_oe;
    logic [5:0]  irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_aon_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] sel_v;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        wait_edges(3);
        rst = 1'b0;
        wait_edges(1);

        // R1 reset state
        chk("R1 pin_oe", 32'(pin_oe), 32'h0);
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        rd_chk("R1 oe reg", 12'h29C, 32'h0);
        rd_chk("R1 out reg", 12'h2A0, 32'h0);
        rd_chk("R1 sel reg", 12'h294, 32'h0);
        rd_chk("R1 pol reg", 12'h290, 32'h0);

        // R2 R3 direction and output value
        wr(12'h29C, 32'h003F_FFFF);
        chk("R3 pin_oe all", 32'(pin_oe), 32'h003F_FFFF);
        chk("R2 out untouched", 32'(pin_out), 32'h0);
        wr(12'h2A0, 32'h002A_AAAA);
        chk("R3 pin_out", 32'(pin_out), 32'h002A_AAAA);
        wr(12'h29C, 32'h0015_5555);
        chk("R3 pin_oe pattern", 32'(pin_oe), 32'h0015_5555);
        rd_chk("R2 oe readback", 12'h29C, 32'h0015_5555);
        rd_chk("R2 out readback", 12'h2A0, 32'h002A_AAAA);
        wr(12'h29C, 32'hFFFF_FFFF);
        rd_chk("R9 oe upper bits", 12'h29C, 32'h003F_FFFF);

        // R4 two-flop input path
        @(negedge clk);
        pin_in = 22'h012345;
        bus_addr = 12'h2A4;
        wait_edges(1);
        rd_chk("R4 after one edge", 12'h2A4, 32'h0);
        wait_edges(1);
        rd_chk("R4 after two edges", 12'h2A4, 32'h0001_2345);
        wr(12'h2A4, 32'hFFFF_FFFF);
        rd_chk("R4 input write ignored", 12'h2A4, 32'h0001_2345);

        // R5 select readback, R2 polarity width
        wr(12'h294, 32'hFFFF_FFFF);
        rd_chk("R5 sel all ones", 12'h294, 32'hFFFF_FFFF);
        wr(12'h294, 32'h5A5A_5A5A);
        rd_chk("R5 sel pattern", 12'h294, 32'h5A5A_5A5A);
        wr(12'h290, 32'hFFFF_FFFF);
        rd_chk("R9 pol upper bits", 12'h290, 32'h0000_003F);

        // R9 unused offsets
        for (int a = 12'h280; a <= 12'h2BC; a += 4) begin
            if (a != 12'h290 && a != 12'h294 && a != 12'h29C && a != 12'h2A0 && a != 12'h2A4) begin
                wr(12'(a), 32'hFFFF_FFFF);
                rd_chk("R9 unused reads zero", 12'(a), 32'h0);
            end
        end
        rd_chk("R9 unaligned reads zero", 12'h291, 32'h0);
        rd_chk("R9 oe kept", 12'h29C, 32'h003F_FFFF);
        rd_chk("R9 out kept", 12'h2A0, 32'h002A_AAAA);
        rd_chk("R9 sel kept", 12'h294, 32'h5A5A_5A5A);
        rd_chk("R9 pol kept", 12'h290, 32'h0000_003F);

        // R6 R7 R8 full sweep of window, select, polarity, level
        for (int k = 0; k < 6; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int v = 0; v < 2; v++) begin
                        @(negedge clk);
                        pin_in = '0;
                        pin_in[8+k] = v[0];
                        wr(12'h294, s[0] ? (32'h1 << (2*(8+k))) : 32'h0);
                        wr(12'h290, p[0] ? (32'h1 << k) : 32'h0);
                        wait_edges(3);
                        chk("R6 R7 R8 sweep", 32'(irq_out),
                            (s == 1 && v == p) ? (32'h1 << k) : 32'h0);
                    end
                end
            end
        end

        // R8 pins outside the window, and odd select bits
        sel_v = '0;
        for (int n = 0; n < 16; n++)
            if (n < 8 || n > 13) sel_v[2*n] = 1'b1;
        @(negedge clk);
        pin_in = '0;
        wr(12'h290, 32'h0);
        wr(12'h294, sel_v);
        wait_edges(3);
        chk("R8 outside window", 32'(irq_out), 32'h0);
        sel_v = '0;
        for (int n = 8; n < 14; n++) sel_v[2*n+1] = 1'b1;
        wr(12'h294, sel_v);
        wait_edges(3);
        chk("R5 odd select bit", 32'(irq_out), 32'h0);

        // R10 select write reaches irq one edge later
        wr(12'h294, 32'h0000_0000);
        wait_edges(2);
        wr(12'h294, 32'h0001_0000);
        chk("R10 not yet", 32'(irq_out), 32'h0);
        wait_edges(1);
        chk("R10 one edge later", 32'(irq_out), 32'h1);

        // R7 R10 pin edge and polarity write on the same edge
        wr(12'h294, 32'h0004_0000);
        wr(12'h290, 32'h0000_0000);
        wait_edges(3);
        chk("R7 low-active idle", 32'(irq_out), 32'h2);
        @(negedge clk);
        pin_in[9] = 1'b1;
        bus_addr  = 12'h290;
        bus_wdata = 32'h0000_0002;
        @(negedge clk);
        bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        chk("R7 R10 coincident update", 32'(irq_out), 32'h2);
        @(negedge clk);
        pin_in[9] = 1'b0;
        wait_edges(3);
        chk("R7 high-active released", 32'(irq_out), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule